// File: doc/BRIEF.md
# Register-Mapped Multiply-Accumulate Unit

This block is a word-wide peripheral that sits on a simple synchronous register bus and multiplies two operands. The offset the first operand is written to picks the operation: unsigned multiply, signed multiply, unsigned multiply-accumulate or signed multiply-accumulate. Either operand may be one word (16 bits) or two words (32 bits), and the two widths may be mixed. Software loads the first operand, then writes the second operand. The write of the second operand, or of its upper word when it is 32 bits wide, starts the operation. The result can be read on the next cycle.

The result is held as a 64-bit value and read as four 16-bit words. For 16x16 work, the two low words are also visible at two extra offsets. A read-only sum-extension word and a carry flag describe what happened above the result. Accumulation adds the new product to whatever the result registers hold. Software can preload those registers by writing them.

A control word shows the current mode, the two operand-width flags and the carry flag. It also holds four option bits (saturation, fractional, delayed-write enable and delayed-write status). These option bits are stored and read back only.

Top module: `regmac`

## Requirements
- R1: After reset, every result word, the sum extension and the control word (offset 0x2C) read 0x0000.
- R2: Unsigned multiply is selected by a first operand at 0x00 (16 bit) or 0x10 low / 0x12 high (32 bit). A second operand written at 0x08 (16 bit), or at 0x20 low then 0x22 high (32 bit), starts the operation. The 64-bit product is readable on the next cycle at 0x24, 0x26, 0x28 and 0x2A, least significant word first, and its two low words also at 0x0A and 0x0C. The sum extension reads 0x0000 and the carry is 0.
- R3: Signed multiply is selected by 0x02 (16 bit) or 0x14/0x16 (32 bit) and uses two's complement. The sum extension reads 0xFFFF for a negative result and 0x0000 otherwise, and the carry equals the sign of the result.
- R4: Unsigned accumulate is selected by 0x04 or 0x18/0x1A and adds the product to the current result. When both operands are 16 bits, the sum is taken over the low 32 bits and the upper two words are cleared. Otherwise the sum is taken over 64 bits. The carry is the carry out of that sum, and the sum extension reads 0x0001 on carry and 0x0000 otherwise.
- R5: Signed accumulate is selected by 0x06 or 0x1C/0x1E and sums as in R4. The carry is the carry out of the sum. The sum extension is 0xFFFF for a negative sum and 0x0000 otherwise. For 16x16 work, the upper two words hold the sign fill.
- R6: A 16-bit operand used with a 32-bit one is zero-extended in the unsigned modes and sign-extended in the signed modes.
- R7: Control word layout: bits 5:4 hold the mode (0 multiply, 1 signed multiply, 2 accumulate, 3 signed accumulate), bit 6 flags a 32-bit first operand, bit 7 flags a 32-bit second operand, and bit 0 is the carry. Bits 1 and 15:10 read 0. Writing the control word sets the mode, the width flags and the carry used by the next operation.
- R8: Control bits 2, 3, 8 and 9 store the written value and read it back, with no effect on the arithmetic.
- R9: The sum extension at 0x0E is read-only, and a write to it changes nothing.
- R10: Writing 0x0A, 0x0C or 0x24 to 0x2A loads that result word, which presets the accumulator.
- R11: The starting write uses the second-operand value it carries, so starts on consecutive cycles each take effect in order.
- R12: Writing a first operand, or the low word of a 32-bit second operand, leaves the result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | 6 | Byte offset of the register (even) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |

## Verification
The write that loads the second operand is also the write that starts the arithmetic, so the operand update and the computation fall in the same cycle. The bench provokes this by issuing starts on consecutive cycles with different operand values, both through the 16-bit start offset and through the upper word of a 32-bit operand. It also accumulates so that each result depends on the one before. Every result word, the sum extension and the control word are then compared against a reference model that always uses the newly written operand, never the stale one.

// File: rtl/regmac_pkg.sv
package regmac_pkg;

  typedef enum logic [1:0] {
    MD_MUL  = 2'd0,
    MD_SMUL = 2'd1,
    MD_MAC  = 2'd2,
    MD_SMAC = 2'd3
  } mode_e;

  // Byte offsets of the register window
  localparam int OFS_OP2      = 'h08;
  localparam int OFS_RLO      = 'h0A;
  localparam int OFS_RHI      = 'h0C;
  localparam int OFS_SUMEXT   = 'h0E;
  localparam int OFS_OP1W     = 'h10;
  localparam int OFS_OP2W_LO  = 'h20;
  localparam int OFS_OP2W_HI  = 'h22;
  localparam int OFS_RES0     = 'h24;
  localparam int OFS_RES3     = 'h2A;
  localparam int OFS_CTL      = 'h2C;

  // Control word bit positions
  localparam int CB_CARRY = 0;
  localparam int CB_FRAC  = 2;
  localparam int CB_SAT   = 3;
  localparam int CB_MODE  = 4;
  localparam int CB_W1    = 6;
  localparam int CB_W2    = 7;
  localparam int CB_DLYEN = 8;
  localparam int CB_DLY   = 9;

  typedef struct packed {
    logic       op1_lo;
    logic       op1_hi;
    logic       op1_wide;
    mode_e      mode;
    logic       op2_lo;
    logic       op2_hi;
    logic       op2_wide;
    logic       start;
    logic       res_wr;
    logic [1:0] res_idx;
    logic       ctl_wr;
  } strobe_t;

endpackage

// File: rtl/regmac_decode.sv
module regmac_decode
  import regmac_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  output strobe_t       st
);

  logic [AW-1:0] res_off;
  assign res_off = addr - AW'(OFS_RES0);

  always_comb begin
    st = '0;
    st.mode = mode_e'(addr[2:1]);
    if (wr_en && !addr[0]) begin
      if (addr < AW'(OFS_OP2)) begin
        st.op1_lo = 1'b1;
        st.mode   = mode_e'(addr[2:1]);
      end else if (addr == AW'(OFS_OP2)) begin
        st.op2_lo = 1'b1;
        st.start  = 1'b1;
      end else if (addr == AW'(OFS_RLO)) begin
        st.res_wr  = 1'b1;
        st.res_idx = 2'd0;
      end else if (addr == AW'(OFS_RHI)) begin
        st.res_wr  = 1'b1;
        st.res_idx = 2'd1;
      end else if (addr >= AW'(OFS_OP1W) && addr < AW'(OFS_OP2W_LO)) begin
        st.mode     = mode_e'(addr[3:2]);
        st.op1_wide = 1'b1;
        st.op1_hi   = addr[1];
        st.op1_lo   = !addr[1];
      end else if (addr == AW'(OFS_OP2W_LO)) begin
        st.op2_lo   = 1'b1;
        st.op2_wide = 1'b1;
      end else if (addr == AW'(OFS_OP2W_HI)) begin
        st.op2_hi   = 1'b1;
        st.op2_wide = 1'b1;
        st.start    = 1'b1;
      end else if (addr >= AW'(OFS_RES0) && addr <= AW'(OFS_RES3)) begin
        st.res_wr  = 1'b1;
        st.res_idx = res_off[2:1];
      end else if (addr == AW'(OFS_CTL)) begin
        st.ctl_wr = 1'b1;
      end
    end
  end

endmodule

// File: rtl/regmac_arith.sv
module regmac_arith
  import regmac_pkg::*;
#(
  parameter int DW = 16
) (
  input  mode_e            mode,
  input  logic             op1_wide,
  input  logic             op2_wide,
  input  logic [2*DW-1:0]  op1,
  input  logic [2*DW-1:0]  op2,
  input  logic [4*DW-1:0]  acc,
  output logic [4*DW-1:0]  res_next,
  output logic [DW-1:0]    sumext_next,
  output logic             carry_next
);

  localparam int OW = 2 * DW;
  localparam int RW = 4 * DW;

  // Extend an operand to the full result width per width flag and signedness
  function automatic logic [RW-1:0] widen(logic [OW-1:0] v, logic wide, logic sgn);
    logic [RW-1:0] r;
    if (wide) r = sgn ? {{(RW-OW){v[OW-1]}}, v} : {{(RW-OW){1'b0}}, v};
    else      r = sgn ? {{(RW-DW){v[DW-1]}}, v[DW-1:0]} : {{(RW-DW){1'b0}}, v[DW-1:0]};
    return r;
  endfunction

  logic          sgn, accum, narrow, neg, cy;
  logic [RW-1:0] prod;
  logic [OW:0]   sum_n;
  logic [RW:0]   sum_w;
  logic [OW-1:0] low_n;

  assign sgn    = mode[0];
  assign accum  = mode[1];
  assign narrow = !op1_wide && !op2_wide;
  assign prod   = widen(op1, op1_wide, sgn) * widen(op2, op2_wide, sgn);
  assign sum_n  = {1'b0, acc[OW-1:0]} + {1'b0, prod[OW-1:0]};
  assign sum_w  = {1'b0, acc} + {1'b0, prod};

  always_comb begin
    if (narrow) begin
      low_n    = accum ? sum_n[OW-1:0] : prod[OW-1:0];
      cy       = accum & sum_n[OW];
      neg      = low_n[OW-1];
      res_next = {(sgn ? {OW{neg}} : {OW{1'b0}}), low_n};
    end else begin
      low_n    = '0;
      res_next = accum ? sum_w[RW-1:0] : prod;
      cy       = accum & sum_w[RW];
      neg      = res_next[RW-1];
    end
    carry_next  = accum ? cy : (sgn & neg);
    sumext_next = sgn ? {DW{neg}} : (accum ? {{(DW-1){1'b0}}, cy} : {DW{1'b0}});
  end

endmodule

// File: rtl/regmac.sv
module regmac
  import regmac_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int OW = 2 * DW;
  localparam int RW = 4 * DW;

  strobe_t       st;
  logic [OW-1:0] op1_q, op2_q, op2_next;
  logic [RW-1:0] res_q, res_next;
  logic [DW-1:0] sumext_q, sumext_next, ctl_word;
  logic          carry_q, carry_next;
  logic          op1_wide_q, op2_wide_q, op2_wide_next;
  mode_e         mode_q;
  logic          sat_q, frac_q, dlyen_q, dly_q;

  // Named internal events for the checker
  logic start_w, res_wr_w, ctl_wr_w;
  assign start_w  = st.start;
  assign res_wr_w = st.res_wr;
  assign ctl_wr_w = st.ctl_wr;

  regmac_decode #(.AW(AW)) u_dec (.wr_en(wr_en), .addr(addr), .st(st));

  // The starting write carries the operand the arithmetic uses
  always_comb begin
    op2_next = op2_q;
    if (st.op2_lo) op2_next[DW-1:0]  = wdata;
    if (st.op2_hi) op2_next[OW-1:DW] = wdata;
    if (st.op2_lo || st.op2_hi) op2_wide_next = st.op2_wide;
    else if (st.ctl_wr)         op2_wide_next = wdata[CB_W2];
    else                        op2_wide_next = op2_wide_q;
  end

  regmac_arith #(.DW(DW)) u_arith (
    .mode(mode_q), .op1_wide(op1_wide_q), .op2_wide(op2_wide_next),
    .op1(op1_q), .op2(op2_next), .acc(res_q),
    .res_next(res_next), .sumext_next(sumext_next), .carry_next(carry_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op1_q      <= '0;
      op2_q      <= '0;
      res_q      <= '0;
      sumext_q   <= '0;
      carry_q    <= 1'b0;
      op1_wide_q <= 1'b0;
      op2_wide_q <= 1'b0;
      mode_q     <= MD_MUL;
      sat_q      <= 1'b0;
      frac_q     <= 1'b0;
      dlyen_q    <= 1'b0;
      dly_q      <= 1'b0;
    end else begin
      op2_q      <= op2_next;
      op2_wide_q <= op2_wide_next;
      if (st.op1_lo) op1_q[DW-1:0]  <= wdata;
      if (st.op1_hi) op1_q[OW-1:DW] <= wdata;
      if (st.op1_lo || st.op1_hi) begin
        mode_q     <= st.mode;
        op1_wide_q <= st.op1_wide;
      end else if (st.ctl_wr) begin
        mode_q     <= mode_e'(wdata[CB_MODE +: 2]);
        op1_wide_q <= wdata[CB_W1];
      end
      if (st.start) begin
        res_q    <= res_next;
        sumext_q <= sumext_next;
        carry_q  <= carry_next;
      end else begin
        if (st.res_wr) res_q[st.res_idx*DW +: DW] <= wdata;
        if (st.ctl_wr) carry_q <= wdata[CB_CARRY];
      end
      if (st.ctl_wr) begin
        sat_q   <= wdata[CB_SAT];
        frac_q  <= wdata[CB_FRAC];
        dlyen_q <= wdata[CB_DLYEN];
        dly_q   <= wdata[CB_DLY];
      end
    end
  end

  always_comb begin
    ctl_word                 = '0;
    ctl_word[CB_CARRY]       = carry_q;
    ctl_word[CB_FRAC]        = frac_q;
    ctl_word[CB_SAT]         = sat_q;
    ctl_word[CB_MODE +: 2]   = mode_q;
    ctl_word[CB_W1]          = op1_wide_q;
    ctl_word[CB_W2]          = op2_wide_q;
    ctl_word[CB_DLYEN]       = dlyen_q;
    ctl_word[CB_DLY]         = dly_q;
  end

  logic [AW-1:0] rd_off;
  assign rd_off = addr - AW'(OFS_RES0);

  always_comb begin
    rdata = '0;
    if (addr < AW'(OFS_OP2))                                   rdata = op1_q[DW-1:0];
    else if (addr == AW'(OFS_OP2) || addr == AW'(OFS_OP2W_LO)) rdata = op2_q[DW-1:0];
    else if (addr == AW'(OFS_RLO))                             rdata = res_q[DW-1:0];
    else if (addr == AW'(OFS_RHI))                             rdata = res_q[OW-1:DW];
    else if (addr == AW'(OFS_SUMEXT))                          rdata = sumext_q;
    else if (addr >= AW'(OFS_OP1W) && addr < AW'(OFS_OP2W_LO))
      rdata = addr[1] ? op1_q[OW-1:DW] : op1_q[DW-1:0];
    else if (addr == AW'(OFS_OP2W_HI))                         rdata = op2_q[OW-1:DW];
    else if (addr >= AW'(OFS_RES0) && addr <= AW'(OFS_RES3))   rdata = res_q[rd_off[2:1]*DW +: DW];
    else if (addr == AW'(OFS_CTL))                             rdata = ctl_word;
  end

endmodule

// File: rtl/regmac_chk.sv
module regmac_chk #(
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            res_wr,
  input logic            ctl_wr,
  input logic [1:0]      mode,
  input logic [DW-1:0]   wdata,
  input logic [DW-1:0]   sumext,
  input logic            carry,
  input logic            sat,
  input logic            frac,
  input logic [4*DW-1:0] res
);

  a_r2_unsigned_no_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode == 2'd0) |=> (sumext == '0 && !carry));

  a_r3_signed_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode == 2'd1) |=> (sumext == {DW{res[4*DW-1]}} && carry == res[4*DW-1]));

  a_r4_mac_carry_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode == 2'd2) |=> (sumext == {{(DW-1){1'b0}}, carry}));

  a_r5_smac_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode == 2'd3) |=> (sumext == {DW{res[4*DW-1]}}));

  a_r8_options_stored: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (sat == $past(wdata[3]) && frac == $past(wdata[2])));

  a_r9_sumext_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(sumext));

  a_r12_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !res_wr) |=> $stable(res));

endmodule

bind regmac regmac_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start_w), .res_wr(res_wr_w), .ctl_wr(ctl_wr_w),
  .mode(mode_q), .wdata(wdata), .sumext(sumext_q), .carry(carry_q),
  .sat(sat_q), .frac(frac_q), .res(res_q)
);

// File: tb/regmac_bench.sv
module regmac_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regmac u_regmac (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                   .wdata(wdata), .rdata(rdata));

  // Reference model state
  logic [31:0] m_op1, m_op2;
  logic [63:0] m_res;
  logic [15:0] m_se;
  logic [1:0]  m_mode;
  logic        m_w1, m_w2, m_c, m_sat, m_frac, m_dlyen, m_dly;

  // Scoreboard queues
  logic [15:0] q_exp[$];
  logic [5:0]  q_adr[$];
  string       q_tag[$];
  bit          rd_act = 1'b0;

  function automatic logic [15:0] m_ctl();
    return {6'b0, m_dly, m_dlyen, m_w2, m_w1, m_mode, m_sat, m_frac, 1'b0, m_c};
  endfunction

  task automatic m_compute();
    logic [63:0] ea, eb, p, r;
    logic [32:0] s33;
    logic [64:0] s65;
    logic sg, cy;
    if (m_mode[0]) begin
      ea = m_w1 ? {{32{m_op1[31]}}, m_op1} : {{48{m_op1[15]}}, m_op1[15:0]};
      eb = m_w2 ? {{32{m_op2[31]}}, m_op2} : {{48{m_op2[15]}}, m_op2[15:0]};
    end else begin
      ea = m_w1 ? {32'b0, m_op1} : {48'b0, m_op1[15:0]};
      eb = m_w2 ? {32'b0, m_op2} : {48'b0, m_op2[15:0]};
    end
    p = ea * eb;
    cy = 1'b0;
    if (!m_w1 && !m_w2) begin
      if (m_mode[1]) begin
        s33 = {1'b0, m_res[31:0]} + {1'b0, p[31:0]};
        cy = s33[32];
        r[31:0] = s33[31:0];
      end else r[31:0] = p[31:0];
      sg = r[31];
      r[63:32] = m_mode[0] ? {32{sg}} : 32'b0;
    end else begin
      if (m_mode[1]) begin
        s65 = {1'b0, m_res} + {1'b0, p};
        cy = s65[64];
        r = s65[63:0];
      end else r = p;
      sg = r[63];
    end
    m_res = r;
    case (m_mode)
      2'd0: begin m_c = 1'b0; m_se = 16'h0000; end
      2'd1: begin m_c = sg;   m_se = {16{sg}}; end
      2'd2: begin m_c = cy;   m_se = {15'b0, cy}; end
      default: begin m_c = cy; m_se = {16{sg}}; end
    endcase
  endtask

  task automatic m_write(logic [5:0] a, logic [15:0] d);
    if (a < 6'h08) begin
      m_op1[15:0] = d; m_mode = a[2:1]; m_w1 = 1'b0;
    end else if (a == 6'h08) begin
      m_op2[15:0] = d; m_w2 = 1'b0; m_compute();
    end else if (a == 6'h0A) m_res[15:0] = d;
    else if (a == 6'h0C) m_res[31:16] = d;
    else if (a >= 6'h10 && a < 6'h20) begin
      if (a[1]) m_op1[31:16] = d; else m_op1[15:0] = d;
      m_mode = a[3:2]; m_w1 = 1'b1;
    end else if (a == 6'h20) begin
      m_op2[15:0] = d; m_w2 = 1'b1;
    end else if (a == 6'h22) begin
      m_op2[31:16] = d; m_w2 = 1'b1; m_compute();
    end else if (a >= 6'h24 && a <= 6'h2A) m_res[(a - 6'h24) * 8 +: 16] = d;
    else if (a == 6'h2C) begin
      m_c = d[0]; m_frac = d[2]; m_sat = d[3]; m_mode = d[5:4];
      m_w1 = d[6]; m_w2 = d[7]; m_dlyen = d[8]; m_dly = d[9];
    end
  endtask

  // Driver tasks
  task automatic wr(logic [5:0] a, logic [15:0] d);
    @(posedge clk); #1;
    rd_act = 1'b0;
    wr_en = 1'b1; addr = a; wdata = d;
    m_write(a, d);
  endtask

  task automatic rd(logic [5:0] a, logic [15:0] e, string tag);
    @(posedge clk); #1;
    wr_en = 1'b0; addr = a;
    q_exp.push_back(e); q_adr.push_back(a); q_tag.push_back(tag);
    rd_act = 1'b1;
  endtask

  task automatic check_all(string tag);
    rd(6'h24, m_res[15:0], tag);
    rd(6'h26, m_res[31:16], tag);
    rd(6'h28, m_res[47:32], tag);
    rd(6'h2A, m_res[63:48], tag);
    rd(6'h0A, m_res[15:0], tag);
    rd(6'h0C, m_res[31:16], tag);
    rd(6'h0E, m_se, tag);
    rd(6'h2C, m_ctl(), "R7");
  endtask

  // Monitor: pops expected items and compares them with the read port
  always @(negedge clk) begin
    if (rd_act && q_exp.size() > 0) begin
      logic [15:0] e;
      logic [5:0]  a;
      string       t;
      e = q_exp.pop_front(); a = q_adr.pop_front(); t = q_tag.pop_front();
      n_tests++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s addr=0x%02h actual=0x%04h expected=0x%04h", t, a, rdata, e);
      end
    end
  end

  logic [31:0] lf = 32'hACE1_2B37;
  function automatic logic [31:0] lf_next(logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    string mtag[4];
    mtag[0] = "R2"; mtag[1] = "R3"; mtag[2] = "R4"; mtag[3] = "R5";
    m_op1 = '0; m_op2 = '0; m_res = '0; m_se = '0; m_mode = '0;
    m_w1 = 0; m_w2 = 0; m_c = 0; m_sat = 0; m_frac = 0; m_dlyen = 0; m_dly = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    check_all("R1");

    // R12: loading a first operand leaves the result alone
    wr(6'h00, 16'hFFFF);
    check_all("R12");
    wr(6'h08, 16'hFFFF);
    check_all("R2");

    wr(6'h02, 16'hFFFE);
    wr(6'h08, 16'h0003);
    check_all("R3");

    // R4 accumulate with carry out of the 32-bit sum
    wr(6'h04, 16'hFFFF);
    wr(6'h08, 16'hFFFF);
    check_all("R4");
    wr(6'h08, 16'hFFFF);
    check_all("R4");

    // R10 preload, then R5 signed accumulate on top
    wr(6'h24, 16'h1111);
    wr(6'h26, 16'h8000);
    wr(6'h28, 16'h3333);
    wr(6'h2A, 16'h4444);
    wr(6'h0A, 16'h0005);
    check_all("R10");
    wr(6'h06, 16'h8000);
    wr(6'h08, 16'h7FFF);
    check_all("R5");

    // 32x32 unsigned; R12 for the low word of the second operand
    wr(6'h10, 16'hFFFF);
    wr(6'h12, 16'hFFFF);
    wr(6'h20, 16'hFFFF);
    check_all("R12");
    wr(6'h22, 16'hFFFF);
    check_all("R2");

    wr(6'h14, 16'h0000);
    wr(6'h16, 16'h8000);
    wr(6'h20, 16'hFFFF);
    wr(6'h22, 16'h7FFF);
    check_all("R3");

    // R6 mixed widths
    wr(6'h10, 16'h5678);
    wr(6'h12, 16'h1234);
    wr(6'h08, 16'hABCD);
    check_all("R6");
    wr(6'h02, 16'h8001);
    wr(6'h20, 16'h0000);
    wr(6'h22, 16'h0001);
    check_all("R6");

    // R4 64-bit accumulate overflow
    wr(6'h24, 16'hFFFF);
    wr(6'h26, 16'hFFFF);
    wr(6'h28, 16'hFFFF);
    wr(6'h2A, 16'hFFFF);
    wr(6'h18, 16'h0002);
    wr(6'h1A, 16'h0000);
    wr(6'h20, 16'h0001);
    wr(6'h22, 16'h0000);
    check_all("R4");

    wr(6'h1C, 16'hFFFF);
    wr(6'h1E, 16'hFFFF);
    wr(6'h20, 16'h0003);
    wr(6'h22, 16'h0000);
    check_all("R5");

    // R8 option bits, R7 mode set through the control word
    wr(6'h2C, 16'hFF0D);
    check_all("R8");
    wr(6'h2C, 16'h0010);
    check_all("R7");
    wr(6'h08, 16'hFFFF);
    check_all("R7");

    // R9 sum extension is read-only
    wr(6'h0E, 16'h1234);
    check_all("R9");

    // R11 back-to-back starts
    wr(6'h04, 16'h0007);
    wr(6'h08, 16'h0003);
    wr(6'h08, 16'h0005);
    check_all("R11");
    wr(6'h18, 16'h0001);
    wr(6'h1A, 16'h0001);
    wr(6'h20, 16'h0002);
    wr(6'h22, 16'h0001);
    wr(6'h22, 16'h0002);
    check_all("R11");

    // Every mode and width combination with pseudo-random operands
    for (int m = 0; m < 4; m++) begin
      for (int w1 = 0; w1 < 2; w1++) begin
        for (int w2 = 0; w2 < 2; w2++) begin
          lf = lf_next(lf);
          if (w1 == 1) begin
            wr(6'(16 + 4 * m), lf[15:0]);
            wr(6'(18 + 4 * m), lf[31:16]);
          end else wr(6'(2 * m), lf[15:0]);
          lf = lf_next(lf);
          if (w2 == 1) begin
            wr(6'h20, lf[15:0]);
            wr(6'h22, lf[31:16]);
          end else wr(6'h08, lf[15:0]);
          check_all((w1 != w2) ? "R6" : mtag[m]);
        end
      end
    end

    @(posedge clk); #1;
    rd_act = 1'b0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule